// File: doc/BRIEF.md
# Banked Memory Common-Area Address Remapper

This block sits on the address path between a processor with a 24-bit address bus and one linear external RAM. The processor picks a 64K page with its upper address byte. In every page, one 32K half is a shared common area: each page's copy of that half lands on the same 32K of RAM. The other half of each page is packed into its own 32K slice of RAM, so no RAM is left unused. To move between banks, software changes only the processor's upper address byte.

A small write port holds two settings. The first is a one-bit half-select, which picks whether the lower or the upper half of each page is the common area. The second is an 8-bit common-page value, which places the shared 32K within RAM. The address translation is pure logic with no register stage, so it adds no wait state to a fast memory cycle. A flag output shows whether the current address falls in the common area.

Top module: `bank_common_remap`

## Requirements
- R1: Output address bits 14..0 always equal input address bits 14..0.
- R2: When input bit 15 equals the half-select bit, the access is common. Output bit 15 equals input bit 15, output bits 23..16 equal the common-page value, and `common_hit` is 1.
- R3: When input bit 15 differs from the half-select bit, output bits 22..15 equal input bits 23..16, output bit 23 is 0, and `common_hit` is 0.
- R4: With the half-select bit at 0, addresses with bit 15 = 0 are common. With it at 1, addresses with bit 15 = 1 are common.
- R5: While `rst` is high at a rising clock edge, the half-select bit is cleared to 0 and the common-page value to 0x00.
- R6: With `cfg_we` = 1 at a rising edge, `cfg_sel` = 0 loads the half-select bit from `cfg_wdata[0]`, and `cfg_sel` = 1 loads the common-page value from `cfg_wdata`. The new value is used from that edge onward.
- R7: `mem_addr` and `common_hit` follow changes on `cpu_addr` with no clock edge in between.
- R8: With `cfg_we` = 0, edges leave both settings unchanged, whatever `cfg_sel` and `cfg_wdata` carry.
- R9: In the cycle in which a write is presented, the translation still uses the settings held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the settings register |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the settings |
| cfg_sel | input | 1 | Setting to write: 0 = half-select, 1 = common page |
| cfg_wdata | input | 8 | Write data |
| cpu_addr | input | 24 | Processor address |
| mem_addr | output | 24 | Translated RAM address |
| common_hit | output | 1 | 1 when the current address is in the common area |

## Verification
A settings write and an address translation can fall in the same cycle. The bench provokes this by presenting a write together with an address that the write would remap differently. It requires the output in that cycle to follow the old settings and the output after the edge to follow the new ones. A behavioural model checks every cycle across a pseudo-random mix of writes, idle strobes and addresses in both halves.

// File: rtl/remap_pkg.sv
package remap_pkg;
  typedef enum logic {
    SEL_HALF = 1'b0,
    SEL_PAGE = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs #(
  parameter int PAGE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic                 sel,
  input  logic [PAGE_BITS-1:0] wdata,
  output logic                 half_q,
  output logic [PAGE_BITS-1:0] page_q
);
  import remap_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= 1'b0;
      page_q <= '0;
    end else if (we) begin
      if (cfg_sel_e'(sel) == SEL_HALF) half_q <= wdata[0];
      else                             page_q <= wdata;
    end
  end
endmodule

// File: rtl/remap_addr_path.sv
module remap_addr_path #(
  parameter int ADDR_W    = 24,
  parameter int PAGE_BITS = 8
) (
  input  logic [ADDR_W-1:0]    a_in,
  input  logic                 half_sel,
  input  logic [PAGE_BITS-1:0] page,
  output logic [ADDR_W-1:0]    a_out,
  output logic                 hit
);
  localparam int HB = ADDR_W - PAGE_BITS - 1;

  logic [ADDR_W-1:0] shifted;
  logic [ADDR_W-1:0] shared;

  assign shifted[HB-1:0] = a_in[HB-1:0];
  assign shifted[ADDR_W-1] = 1'b0;
  for (genvar i = 0; i < PAGE_BITS; i++) begin : g_down
    assign shifted[HB+i] = a_in[HB+1+i];
  end

  assign shared = {page, a_in[HB:0]};

  always_comb begin
    hit   = ~(a_in[HB] ^ half_sel);
    a_out = hit ? shared : shifted;
  end
endmodule

// File: rtl/bank_common_remap.sv
module bank_common_remap #(
  parameter int ADDR_W    = 24,
  parameter int PAGE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic                 cfg_sel,
  input  logic [PAGE_BITS-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0]    cpu_addr,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 common_hit
);
  logic                 half_q;
  logic [PAGE_BITS-1:0] page_q;

  remap_cfg_regs #(.PAGE_BITS(PAGE_BITS)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .half_q(half_q), .page_q(page_q)
  );

  remap_addr_path #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_path (
    .a_in(cpu_addr), .half_sel(half_q), .page(page_q),
    .a_out(mem_addr), .hit(common_hit)
  );
endmodule

// File: rtl/bank_common_remap_chk.sv
module bank_common_remap_chk #(
  parameter int ADDR_W    = 24,
  parameter int PAGE_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cfg_we,
  input logic                 cfg_sel,
  input logic [PAGE_BITS-1:0] cfg_wdata,
  input logic [ADDR_W-1:0]    cpu_addr,
  input logic [ADDR_W-1:0]    mem_addr,
  input logic                 common_hit
);
  localparam int HB = ADDR_W - PAGE_BITS - 1;

  assert_low_pass_R1: assert property (@(posedge clk) disable iff (rst)
    mem_addr[HB-1:0] == cpu_addr[HB-1:0]);

  assert_common_half_R2: assert property (@(posedge clk) disable iff (rst)
    common_hit |-> mem_addr[HB] == cpu_addr[HB]);

  assert_shift_down_R3: assert property (@(posedge clk) disable iff (rst)
    !common_hit |-> (mem_addr[ADDR_W-1] == 1'b0 &&
                     mem_addr[ADDR_W-2:HB] == cpu_addr[ADDR_W-1:HB+1]));

  assert_page_write_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel) |=> (common_hit -> mem_addr[ADDR_W-1:HB+1] == $past(cfg_wdata)));

  assert_page_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(cfg_we) && common_hit && $past(common_hit))
      |-> mem_addr[ADDR_W-1:HB+1] == $past(mem_addr[ADDR_W-1:HB+1]));
endmodule

bind bank_common_remap bank_common_remap_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .cpu_addr(cpu_addr), .mem_addr(mem_addr), .common_hit(common_hit)
);

// File: tb/tb_bank_common_remap.sv
module tb_bank_common_remap;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [23:0] cpu_addr = 24'h0;
  logic [23:0] mem_addr;
  logic        common_hit;

  int total = 0;
  int bad = 0;
  int ref_half = 0;
  int ref_page = 0;
  int seed = 32'h1234_5678;

  always #2 clk = ~clk;

  bank_common_remap dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cpu_addr(cpu_addr), .mem_addr(mem_addr), .common_hit(common_hit)
  );

  function automatic int model_addr(int a, int h, int p);
    int b15 = (a >> 15) & 1;
    if (b15 == h) return (p << 16) | (a & 16'hFFFF);
    return (((a >> 16) & 8'hFF) << 15) | (a & 15'h7FFF);
  endfunction

  function automatic int model_hit(int a, int h);
    return (((a >> 15) & 1) == h) ? 1 : 0;
  endfunction

  task automatic check(string tag);
    int ea = model_addr(int'(cpu_addr), ref_half, ref_page);
    int eh = model_hit(int'(cpu_addr), ref_half);
    total++;
    if (int'(mem_addr) != ea || int'(common_hit) != eh) begin
      bad++;
      $display("FAIL %s: addr=%06h mem=%06h hit=%0d expected mem=%06h hit=%0d",
               tag, cpu_addr, mem_addr, common_hit, ea, eh);
    end
  endtask

  // drive at negedge, check mid-low phase, then apply model update at edge
  task automatic step(logic we, logic sel, logic [7:0] d, logic [23:0] a, string tag);
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = d; cpu_addr = a;
    #1 check(tag);
    @(posedge clk);
    if (we) begin
      if (sel) ref_page = int'(d);
      else     ref_half = int'(d[0]);
    end
  endtask

  function automatic int lcg(int s);
    return s * 1103515245 + 12345;
  endfunction

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R5 reset state: half=0, page=0 -> 0x123456 maps to 0x003456 hit
    step(0, 0, 8'h00, 24'h123456, "R5 reset low half common");
    step(0, 0, 8'h00, 24'h12B456, "R3 reset upper half shifted");
    step(0, 0, 8'h00, 24'hFFFFFF, "R3 top bit zero");
    step(0, 0, 8'h00, 24'h007FFF, "R1 low bits pass");
    // R9: write page with a common address in the same cycle
    step(1, 1, 8'hA5, 24'h345678, "R9 page write same cycle old value");
    step(0, 1, 8'h00, 24'h345678, "R6 page write applied");
    step(0, 1, 8'h00, 24'h34D678, "R3 shifted ignores page");
    // R8: strobe low, data/sel toggling
    step(0, 1, 8'h3C, 24'h011111, "R8 no write page held");
    step(0, 0, 8'hFF, 24'h011111, "R8 no write half held");
    step(0, 0, 8'h00, 24'h018888, "R8 half still zero");
    // R4: half select to 1
    step(1, 0, 8'h01, 24'h998000, "R9 half write same cycle old value");
    step(0, 0, 8'h00, 24'h998000, "R4 upper half common");
    step(0, 0, 8'h00, 24'h990000, "R4 lower half shifted");
    step(1, 1, 8'h00, 24'hF0F0F0, "R6 page write to zero");
    step(0, 0, 8'h00, 24'hF0F0F0, "R2 common page zero");
    // R7: address changes with no edge between
    @(negedge clk);
    cfg_we = 0; cpu_addr = 24'h5A8123;
    #0.5 check("R7 comb first");
    cpu_addr = 24'h5A0123;
    #0.5 check("R7 comb second");
    // mixed random sweep
    for (int i = 0; i < 400; i++) begin
      logic we;
      logic sel;
      logic [7:0] d;
      logic [23:0] a;
      seed = lcg(seed); we = seed[20] & seed[21];
      seed = lcg(seed); sel = seed[19];
      seed = lcg(seed); d = seed[23:16];
      seed = lcg(seed); a = seed[27:4];
      step(we, sel, d, a, "R2 R3 R6 R8 sweep");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule